// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial-bus slave that holds fifteen 8-bit control registers at indices 00h to 0Eh and presents their contents to the rest of the chip. It runs entirely in the system clock domain. The bus clock and data lines are oversampled through a synchronizer and a majority vote. Start, stop and repeated-start conditions are recovered from the filtered lines, and bytes are shifted most significant bit first.

A host selects the device with a 7-bit address whose upper five bits are fixed and whose lower two bits come from strap pins. In a write transfer, the first byte after the address is a register index. Each byte after that is stored at the index, which then advances. A read transfer returns bytes starting at the stored index and advances the same way. The index never moves past the top register, and an index above the top register is refused.

One register is special. Its port-phase control is accepted in bit 4 on a write and is returned in bit 7 on a read, together with a fixed revision code. The data line is driven only through an open-drain enable.

Top module: `twr_regfile_slave`

## Requirements
- R1: The device answers to address 1,0,0,1,1,strap_i[1],strap_i[0] (bits sent MSB first, then R/W). On a match it pulls SDA low during the ninth SCL pulse. On a mismatch it leaves SDA released and ignores the rest of the transfer.
- R2: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. Either one abandons a partly received byte without storing it. A start with no stop before it (a repeated start) begins a new address phase.
- R3: After an address with R/W = 0, the next byte is the register index, and each following byte is written to the index and then to index+1, index+2, and so on. Every data byte is acknowledged.
- R4: The index advances after each byte written or read, and it stays at 0Eh once it has reached 0Eh.
- R5: An index byte greater than 0Eh is not acknowledged and does not change the stored index.
- R6: With R/W = 1, data is returned from the stored index and the index advances after each byte. When the host does not acknowledge a byte, the slave releases SDA and stays released until the next start or stop.
- R7: Register 0Dh keeps only bit 4 of a written byte, and regs_o shows it at bit 4. A read of 0Dh returns that bit in bit 7, the revision code REV_ID in bits 3..1, and zero in all other bits.
- R8: After reset, register 0Bh is 80h (phase field 16 in bits 7..3), register 0Ch is 24h (range 01 in bits 6..5, current 001 in bits 4..2), all other registers are 00h, and SDA is released.
- R9: sda_oe_o changes only while the filtered SCL is low. The acknowledge drive is removed after the SCL falling edge that ends the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Low two address bits from strap pins |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| regs_o | output | NREG*8 | Register contents, register n in bits n*8+7..n*8 |

## Verification
The bench drives the slave with a set of transfers that each separate one behaviour from another:
- single-byte and multi-byte writes, which show whether the index advances at all;
- a run of writes and a run of reads that cross 0Eh, which separate saturation from wrap-around;
- a refused index followed by a read, which shows whether the refused value reached the pointer;
- a write to a foreign address, which separates a true mismatch from a late one;
- a byte cut off by a stop and then a clean rewrite, which shows whether partial data leaks into a register;
- reads of 0Dh, which separate the write position of the port-phase bit from its readback position.

A model in the bench keeps the expected register image and compares it with regs_o on every idle clock.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_INDEX,
    S_WDATA,
    S_ACK,
    S_RDATA,
    S_HOSTACK,
    S_WAIT
  } twr_state_e;

  function automatic logic [7:0] twr_reset_value(input int idx);
    case (idx)
      11:      return 8'h80;
      12:      return 8'h24;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/twr_deglitch.sv
module twr_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE        = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(VOTE + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE-1:0]        win_q;
  logic [CW-1:0]          ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE; i++) ones = ones + CW'(win_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      win_q  <= {win_q[VOTE-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= (ones > CW'(VOTE / 2));
    end
  end

endmodule

// File: rtl/twr_regs.sv
module twr_regs #(
  parameter int         NREG     = 15,
  parameter int         AW       = 4,
  parameter int         PH_REG   = 13,
  parameter int         PH_WR    = 4,
  parameter int         PH_RD    = 7,
  parameter logic [2:0] REV_ID   = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [7:0]        wdata,
  input  logic [AW-1:0]     raddr,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] regs_o
);
  import twr_pkg::*;

  localparam logic [AW-1:0] TOP     = AW'(NREG - 1);
  localparam logic [AW-1:0] PH_IDX  = AW'(PH_REG);
  localparam logic [7:0]    PH_MASK = 8'(1 << PH_WR);

  logic [7:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= twr_reset_value(i);
    end else if (we && (waddr <= TOP)) begin
      mem[waddr] <= (waddr == PH_IDX) ? (wdata & PH_MASK) : wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (raddr == PH_IDX) begin
      rdata[PH_RD] = mem[PH_REG][PH_WR];
      rdata[3:1]   = REV_ID;
    end else if (raddr <= TOP) begin
      rdata = mem[raddr];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = mem[g];
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr <= TOP)) else $error("write index out of range"); // R3

endmodule

// File: rtl/twr_link.sv
module twr_link #(
  parameter int         NREG   = 15,
  parameter int         AW     = 4,
  parameter logic [4:0] DEV_ID = 5'b10011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [1:0]    strap,
  input  logic [7:0]    rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic [AW-1:0] ptr,
  output logic          sda_oe
);
  import twr_pkg::*;

  localparam logic [AW-1:0] TOP  = AW'(NREG - 1);
  localparam logic [7:0]    TOP8 = 8'(NREG - 1);

  twr_state_e st, nxt;
  logic       scl_q, sda_q;
  logic [6:0] sh;
  logic [7:0] tx;
  logic [3:0] cnt;
  logic       ack_q, ack_phase, host_ack;

  wire        rise     = scl_f && !scl_q;
  wire        fall     = !scl_f && scl_q;
  wire        start_c  = scl_f && scl_q && sda_q && !sda_f;
  wire        stop_c   = scl_f && scl_q && !sda_q && sda_f;
  wire [7:0]  rx_byte  = {sh, sda_f};
  wire        last_bit = (cnt == 4'd7);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == TOP) ? p : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  nxt <= S_IDLE;
      scl_q <= 1'b1; sda_q <= 1'b1;
      sh <= '0; tx <= '0; cnt <= '0;
      ack_q <= 1'b0; ack_phase <= 1'b0; host_ack <= 1'b0;
      we <= 1'b0; waddr <= '0; wdata <= '0; ptr <= '0;
      sda_oe <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      we    <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_INDEX, S_WDATA: begin
            if (rise) begin
              sh  <= rx_byte[6:0];
              cnt <= cnt + 1'b1;
              if (last_bit) begin
                st        <= S_ACK;
                ack_phase <= 1'b0;
                if (st == S_ADDR) begin
                  ack_q <= (rx_byte[7:1] == {DEV_ID, strap});
                  nxt   <= (rx_byte[7:1] != {DEV_ID, strap}) ? S_WAIT :
                           (rx_byte[0] ? S_RDATA : S_INDEX);
                end else if (st == S_INDEX) begin
                  ack_q <= (rx_byte <= TOP8);
                  nxt   <= (rx_byte <= TOP8) ? S_WDATA : S_WAIT;
                  if (rx_byte <= TOP8) ptr <= rx_byte[AW-1:0];
                end else begin
                  ack_q <= 1'b1;
                  nxt   <= S_WDATA;
                  we    <= 1'b1;
                  waddr <= ptr;
                  wdata <= rx_byte;
                  ptr   <= step(ptr);
                end
              end
            end
          end
          S_ACK: begin
            if (fall) begin
              if (!ack_phase) begin
                sda_oe    <= ack_q;
                ack_phase <= 1'b1;
              end else begin
                cnt <= '0;
                st  <= nxt;
                if (nxt == S_RDATA) begin
                  tx     <= rdata;
                  sda_oe <= ~rdata[7];
                end else begin
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          S_RDATA: begin
            if (rise) begin
              cnt <= cnt + 1'b1;
              if (last_bit) ptr <= step(ptr);
            end else if (fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_HOSTACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          S_HOSTACK: begin
            if (rise) begin
              host_ack <= !sda_f;
            end else if (fall) begin
              if (host_ack) begin
                tx     <= rdata;
                sda_oe <= ~rdata[7];
                cnt    <= '0;
                st     <= S_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f) else $error("SDA drive changed with SCL high"); // R9
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !sda_oe) else $error("SDA held after stop"); // R2
  AST_NACK_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACK && !ack_q) |-> !sda_oe) else $error("refused byte acknowledged"); // R5
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ptr <= TOP) else $error("index past top register"); // R4

endmodule

// File: rtl/twr_regfile_slave.sv
module twr_regfile_slave #(
  parameter int         NREG        = 15,
  parameter int         SYNC_STAGES = 2,
  parameter int         VOTE        = 3,
  parameter logic [4:0] DEV_ID      = 5'b10011,
  parameter logic [2:0] REV_ID      = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int AW = $clog2(NREG);

  logic          scl_f, sda_f, we;
  logic [AW-1:0] waddr, ptr;
  logic [7:0]    wdata, rdata;

  twr_deglitch #(.SYNC_STAGES(SYNC_STAGES), .VOTE(VOTE)) u_scl (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_f));
  twr_deglitch #(.SYNC_STAGES(SYNC_STAGES), .VOTE(VOTE)) u_sda (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_f));

  twr_link #(.NREG(NREG), .AW(AW), .DEV_ID(DEV_ID)) u_link (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f), .strap(strap_i),
    .rdata(rdata), .we(we), .waddr(waddr), .wdata(wdata), .ptr(ptr),
    .sda_oe(sda_oe_o));

  twr_regs #(.NREG(NREG), .AW(AW), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata), .regs_o(regs_o));

endmodule

// File: tb/sim_twr_regfile_slave.sv
module sim_twr_regfile_slave;
  localparam int CLK_NS = 10;
  localparam int Q      = 8;
  localparam int NREG   = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire  sda_line = m_sda & ~sda_oe;

  int tests = 0, fails = 0;
  logic cmp_en = 1'b0, mis_seen = 1'b0, done = 1'b0;
  logic [7:0] exp_regs [NREG];

  always #(CLK_NS/2) clk = ~clk;

  twr_regfile_slave u0 (.clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs_o));

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    if (a == 13) return {exp_regs[13][4], 3'b000, 3'b101, 1'b0};
    return exp_regs[a];
  endfunction

  task automatic mdl_wr(input int a, input logic [7:0] d);
    exp_regs[a] = (a == 13) ? (d & 8'h10) : d;
  endtask

  // Reference image compared with regs_o on every idle clock (R3, R7, R8)
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      for (int i = 0; i < NREG; i++) begin
        if (regs_o[i*8 +: 8] !== exp_regs[i] && !mis_seen) begin
          mis_seen = 1'b1;
          fails++;
          $display("FAIL R3 image reg %0d: actual %0h expected %0h", i, regs_o[i*8 +: 8], exp_regs[i]);
        end
      end
    end
  end

  task automatic bus_start;
    cmp_en = 1'b0;
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(3*Q);
    cmp_en = 1'b1;
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    seen = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = !s;
    m_sda = 1'b1;
  endtask

  task automatic rd_byte(input logic host_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(!host_ack, s);
    m_sda = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    exp_regs[11] = 8'h80;
    exp_regs[12] = 8'h24;
    tick(20);
    rst = 1'b0;
    tick(10);
    chk("R8 oe after reset", sda_oe, 0);
    chk("R8 reg 0B default", regs_o[11*8 +: 8], 8'h80);
    chk("R8 reg 0C default", regs_o[12*8 +: 8], 8'h24);
    chk("R8 reg 00 default", regs_o[7:0], 8'h00);
    cmp_en = 1'b1;

    // R1 / R3: two data bytes from index 03
    bus_start;
    wr_byte(8'h9C, a); chk("R1 address ack", a, 1);
    wr_byte(8'h03, a); chk("R3 index ack", a, 1);
    wr_byte(8'hA5, a); chk("R3 data ack", a, 1);
    wr_byte(8'h5A, a); chk("R3 data ack 2", a, 1);
    chk("R9 released after ack slot", sda_oe, 0);
    bus_stop;
    mdl_wr(3, 8'hA5); mdl_wr(4, 8'h5A);
    chk("R3 reg 03", regs_o[3*8 +: 8], 8'hA5);
    chk("R3 reg 04", regs_o[4*8 +: 8], 8'h5A);

    // R4 / R7: writes past the top register pile up at 0E
    bus_start;
    wr_byte(8'h9C, a);
    wr_byte(8'h0D, a); chk("R4 index 0D ack", a, 1);
    wr_byte(8'hFF, a);
    wr_byte(8'h11, a);
    wr_byte(8'h22, a); chk("R4 saturated data ack", a, 1);
    bus_stop;
    mdl_wr(13, 8'hFF); mdl_wr(14, 8'h11); mdl_wr(14, 8'h22);
    chk("R7 reg 0D keeps bit 4 only", regs_o[13*8 +: 8], 8'h10);
    chk("R4 reg 0E last write", regs_o[14*8 +: 8], 8'h22);

    // R1: foreign address is ignored
    bus_start;
    wr_byte(8'h98, a); chk("R1 mismatch no ack", a, 0);
    wr_byte(8'h05, a);
    wr_byte(8'h77, a);
    bus_stop;
    chk("R1 mismatch no write", regs_o[5*8 +: 8], 8'h00);

    // R5: index 0F refused, pointer keeps 0E
    bus_start;
    wr_byte(8'h9C, a);
    wr_byte(8'h0F, a); chk("R5 index 0F no ack", a, 0);
    bus_stop;
    bus_start;
    wr_byte(8'h9D, a); chk("R6 read address ack", a, 1);
    rd_byte(1'b0, d); chk("R5 pointer unchanged", d, 8'h22);
    bus_stop;

    // R2 / R6: repeated start read with host NACK
    bus_start;
    wr_byte(8'h9C, a);
    wr_byte(8'h02, a);
    bus_rstart;
    wr_byte(8'h9D, a); chk("R2 repeated start address ack", a, 1);
    rd_byte(1'b1, d); chk("R6 read 02", d, exp_rd(2));
    rd_byte(1'b1, d); chk("R6 read 03", d, exp_rd(3));
    rd_byte(1'b1, d); chk("R6 read 04", d, exp_rd(4));
    rd_byte(1'b0, d); chk("R6 read 05", d, exp_rd(5));
    tick(Q);
    chk("R6 released after host NACK", sda_line, 1);
    bus_stop;

    // R4 / R7: read across the top register and 0D readback layout
    bus_start;
    wr_byte(8'h9C, a);
    wr_byte(8'h0C, a);
    bus_rstart;
    wr_byte(8'h9D, a);
    rd_byte(1'b1, d); chk("R8 read 0C", d, 8'h24);
    rd_byte(1'b1, d); chk("R7 read 0D", d, 8'h8A);
    rd_byte(1'b1, d); chk("R4 read 0E", d, exp_rd(14));
    rd_byte(1'b0, d); chk("R4 read stays 0E", d, exp_rd(14));
    bus_stop;

    // R2: stop in the middle of a data byte stores nothing
    bus_start;
    wr_byte(8'h9C, a);
    wr_byte(8'h01, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, a);
    bus_stop;
    chk("R2 aborted byte not stored", regs_o[1*8 +: 8], 8'h00);
    bus_start;
    wr_byte(8'h9C, a); chk("R2 ack after abort", a, 1);
    wr_byte(8'h01, a);
    wr_byte(8'h3C, a);
    bus_stop;
    mdl_wr(1, 8'h3C);
    chk("R2 write after abort", regs_o[1*8 +: 8], 8'h3C);

    tick(10);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule